// File: doc/BRIEF.md
# JTAG Chain Select Switcher

This block sits between one board-level test port and a parameterised number of downstream test access ports ("slaves"). TMS goes to every slave in parallel. TCK also goes to every slave, but each slave's copy is gated by that slave's enable bit. The serial data path passes only through the enabled slaves. The host therefore sees a scan chain made of the switcher's own TAP followed by the selected subset of slaves, taken in ascending slave index.

The switcher carries a complete IEEE 1149.1 TAP controller and always sits first in the chain. Its instruction register has a fixed width, and the all-ones code is BYPASS. A dedicated opcode routes the data path through a select register that holds one bit per slave. Update-DR writes that register into a pending copy. The pending copy moves to the live enables only on a TCK rising edge taken while the controller sits in Run-Test/Idle. The chain length therefore never changes in the middle of a scan. A slave that is deselected sees no TCK edges, so it stays frozen in the state it had when it was removed.

Top module: `jtag_chain_switch`

## Requirements
- R1: Five consecutive rising TCK edges with TMS high put the controller in Test-Logic-Reset. That state clears the live and pending enables and loads the all-ones BYPASS code into the instruction register.
- R2: While trst_n is low, slv_en, tdo_oe and every slv_tck output are 0 immediately, with no TCK edge needed. The controller and the registers are held in their reset state.
- R3: tdo_oe is 1 only while the controller is in Shift-IR or Shift-DR. It changes on the falling TCK edge that follows entry to or exit from those states.
- R4: The instruction register is IR_W bits wide and shifts LSB first. Capture-IR loads the value 1: the first bit shifted out is 1 and the remaining captured bits are 0. Update-IR loads the shifted value. Every code except SEL_CODE (default 4'b0010) selects a one-bit bypass register that captures 0.
- R5: With SEL_CODE in the instruction register, the data path is an N_SLAVES-bit select register that shifts LSB first. Bit i enables slave i. Capture-DR loads the live enables, and Update-DR writes the shifted value into the pending enables.
- R6: The live enables (slv_en) change only on a rising TCK edge taken in Run-Test/Idle, where they take the pending value. They therefore appear one TCK cycle after the controller enters Run-Test/Idle. The exception is the clearing in R1.
- R7: The serial path runs host tdi, then the switcher's own register, then each enabled slave in ascending index, then host tdo. Each enabled slave's tdo feeds the slv_tdi of the next enabled slave. With no slave enabled, tdo carries the switcher's own shift output. That output changes on the falling TCK edge.
- R8: slv_tms[i] always equals tms. slv_tck[i] follows tck while slave i is enabled and stays low otherwise. The gate changes only on a falling TCK edge, so no partial pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Host test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Host mode select, sampled on rising tck |
| tdi | input | 1 | Host serial data in |
| tdo | output | 1 | Host serial data out (end of the active chain) |
| tdo_oe | output | 1 | High while tdo carries shift data |
| slv_tck | output | N_SLAVES | Gated test clock per slave |
| slv_tms | output | N_SLAVES | Mode select per slave, copied from tms |
| slv_tdi | output | N_SLAVES | Serial data into each slave |
| slv_tdo | input | N_SLAVES | Serial data out of each slave |
| slv_en | output | N_SLAVES | Live per-slave enables |

## Verification
A wrong controller state shows within one scan: tdo_oe opens on the wrong half-cycle, or a captured value appears at the wrong bit position on tdo. A wrong pending or live enable changes the delay from tdi to tdo by one bit for each slave wrongly counted. It also shifts the bit at which each slave's slv_tdi repeats the switcher's output, and it lets clock edges reach a slave that should be idle. All of this is visible within the first bypass scan after the enables are applied. An enable that is applied too early shows on slv_en in the very cycle the controller passes through Pause or Update, before it reaches Run-Test/Idle.

// File: rtl/jcs_pkg.sv
package jcs_pkg;

  typedef enum logic [3:0] {
    TS_DR_EXIT2 = 4'h0,
    TS_DR_EXIT1 = 4'h1,
    TS_DR_SHIFT = 4'h2,
    TS_DR_PAUSE = 4'h3,
    TS_IR_SEL   = 4'h4,
    TS_DR_UPD   = 4'h5,
    TS_DR_CAP   = 4'h6,
    TS_DR_SEL   = 4'h7,
    TS_IR_EXIT2 = 4'h8,
    TS_IR_EXIT1 = 4'h9,
    TS_IR_SHIFT = 4'hA,
    TS_IR_PAUSE = 4'hB,
    TS_IDLE     = 4'hC,
    TS_IR_UPD   = 4'hD,
    TS_IR_CAP   = 4'hE,
    TS_RESET    = 4'hF
  } tap_state_e;

  function automatic tap_state_e tap_step(input tap_state_e s, input logic m);
    tap_state_e n;
    case (s)
      TS_RESET:    n = m ? TS_RESET    : TS_IDLE;
      TS_IDLE:     n = m ? TS_DR_SEL   : TS_IDLE;
      TS_DR_SEL:   n = m ? TS_IR_SEL   : TS_DR_CAP;
      TS_DR_CAP:   n = m ? TS_DR_EXIT1 : TS_DR_SHIFT;
      TS_DR_SHIFT: n = m ? TS_DR_EXIT1 : TS_DR_SHIFT;
      TS_DR_EXIT1: n = m ? TS_DR_UPD   : TS_DR_PAUSE;
      TS_DR_PAUSE: n = m ? TS_DR_EXIT2 : TS_DR_PAUSE;
      TS_DR_EXIT2: n = m ? TS_DR_UPD   : TS_DR_SHIFT;
      TS_DR_UPD:   n = m ? TS_DR_SEL   : TS_IDLE;
      TS_IR_SEL:   n = m ? TS_RESET    : TS_IR_CAP;
      TS_IR_CAP:   n = m ? TS_IR_EXIT1 : TS_IR_SHIFT;
      TS_IR_SHIFT: n = m ? TS_IR_EXIT1 : TS_IR_SHIFT;
      TS_IR_EXIT1: n = m ? TS_IR_UPD   : TS_IR_PAUSE;
      TS_IR_PAUSE: n = m ? TS_IR_EXIT2 : TS_IR_PAUSE;
      TS_IR_EXIT2: n = m ? TS_IR_UPD   : TS_IR_SHIFT;
      TS_IR_UPD:   n = m ? TS_DR_SEL   : TS_IDLE;
      default:     n = TS_RESET;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/jcs_rst_sync.sv
module jcs_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/jcs_tap_fsm.sv
module jcs_tap_fsm
  import jcs_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state_o,
  output logic       tlr_o,
  output logic       idle_o,
  output logic       cap_dr_o,
  output logic       sh_dr_o,
  output logic       upd_dr_o,
  output logic       cap_ir_o,
  output logic       sh_ir_o,
  output logic       upd_ir_o
);
  tap_state_e state_q, state_d;

  always_comb state_d = tap_step(state_q, tms);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state_q <= TS_RESET;
    else        state_q <= state_d;
  end

  always_comb begin
    tlr_o    = (state_q == TS_RESET);
    idle_o   = (state_q == TS_IDLE);
    cap_dr_o = (state_q == TS_DR_CAP);
    sh_dr_o  = (state_q == TS_DR_SHIFT);
    upd_dr_o = (state_q == TS_DR_UPD);
    cap_ir_o = (state_q == TS_IR_CAP);
    sh_ir_o  = (state_q == TS_IR_SHIFT);
    upd_ir_o = (state_q == TS_IR_UPD);
  end

  assign state_o = state_q;
endmodule

// File: rtl/jcs_instr.sv
module jcs_instr #(
  parameter int IR_W = 4
) (
  input  logic            tck,
  input  logic            rst_n,
  input  logic            tlr,
  input  logic            cap_ir,
  input  logic            sh_ir,
  input  logic            upd_ir,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_o,
  output logic            sr_lsb_o
);
  localparam logic [IR_W-1:0] CAPTURE_VAL = IR_W'(1);
  localparam logic [IR_W-1:0] BYPASS_VAL  = '1;

  logic [IR_W-1:0] sr_q, sr_d, ir_q, ir_d;

  always_comb begin
    sr_d = sr_q;
    if (cap_ir)     sr_d = CAPTURE_VAL;
    else if (sh_ir) sr_d = {tdi, sr_q[IR_W-1:1]};
    ir_d = ir_q;
    if (tlr)         ir_d = BYPASS_VAL;
    else if (upd_ir) ir_d = sr_q;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      ir_q <= BYPASS_VAL;
    end else begin
      sr_q <= sr_d;
      ir_q <= ir_d;
    end
  end

  assign ir_o     = ir_q;
  assign sr_lsb_o = sr_q[0];
endmodule

// File: rtl/jcs_sel_dr.sv
module jcs_sel_dr #(
  parameter int N_SLV = 3
) (
  input  logic             tck,
  input  logic             rst_n,
  input  logic             tlr,
  input  logic             idle,
  input  logic             cap_dr,
  input  logic             sh_dr,
  input  logic             upd_dr,
  input  logic             sel_ir,
  input  logic             tdi,
  output logic             dr_lsb_o,
  output logic [N_SLV-1:0] pend_o,
  output logic [N_SLV-1:0] act_o
);
  logic [N_SLV-1:0] sr_q, sr_d, pend_q, pend_d, act_q, act_d, shifted;
  logic             byp_q, byp_d;

  if (N_SLV > 1) begin : g_wide
    assign shifted = {tdi, sr_q[N_SLV-1:1]};
  end else begin : g_one
    assign shifted = tdi;
  end

  always_comb begin
    sr_d   = sr_q;
    byp_d  = byp_q;
    pend_d = pend_q;
    act_d  = act_q;
    if (sel_ir) begin
      if (cap_dr)     sr_d = act_q;
      else if (sh_dr) sr_d = shifted;
    end else begin
      if (cap_dr)     byp_d = 1'b0;
      else if (sh_dr) byp_d = tdi;
    end
    if (tlr) begin
      pend_d = '0;
      act_d  = '0;
    end else begin
      if (upd_dr && sel_ir) pend_d = sr_q;
      if (idle)             act_d  = pend_q;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      byp_q  <= 1'b0;
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      sr_q   <= sr_d;
      byp_q  <= byp_d;
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign dr_lsb_o = sel_ir ? sr_q[0] : byp_q;
  assign pend_o   = pend_q;
  assign act_o    = act_q;
endmodule

// File: rtl/jcs_route.sv
module jcs_route #(
  parameter int N_SLV = 3
) (
  input  logic             tck,
  input  logic             rst_n,
  input  logic [N_SLV-1:0] act,
  input  logic             own_bit,
  input  logic [N_SLV-1:0] slv_tdo,
  output logic [N_SLV-1:0] slv_tdi,
  output logic [N_SLV-1:0] slv_tck,
  output logic             chain_o
);
  logic [N_SLV:0]   link;
  logic [N_SLV-1:0] gate_q;

  // gate moves while tck is low, so a slave clock never gets a runt pulse
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) gate_q <= '0;
    else        gate_q <= act;
  end

  assign link[0] = own_bit;

  for (genvar i = 0; i < N_SLV; i++) begin : g_slot
    assign slv_tdi[i]  = link[i];
    assign link[i+1]   = act[i] ? slv_tdo[i] : link[i];
    assign slv_tck[i]  = tck & gate_q[i];
  end

  assign chain_o = link[N_SLV];
endmodule

// File: rtl/jtag_chain_switch.sv
module jtag_chain_switch #(
  parameter int              N_SLAVES = 3,
  parameter int              IR_W     = 4,
  parameter logic [IR_W-1:0] SEL_CODE = 4'b0010
) (
  input  logic                tck,
  input  logic                trst_n,
  input  logic                tms,
  input  logic                tdi,
  output logic                tdo,
  output logic                tdo_oe,
  output logic [N_SLAVES-1:0] slv_tck,
  output logic [N_SLAVES-1:0] slv_tms,
  output logic [N_SLAVES-1:0] slv_tdi,
  input  logic [N_SLAVES-1:0] slv_tdo,
  output logic [N_SLAVES-1:0] slv_en
);
  import jcs_pkg::*;

  logic                rst_n;
  tap_state_e          tap_state;
  logic                st_tlr, st_idle, st_cap_dr, st_sh_dr, st_upd_dr;
  logic                st_cap_ir, st_sh_ir, st_upd_ir;
  logic [IR_W-1:0]     ir_q;
  logic                ir_lsb, dr_lsb, sel_ir;
  logic [N_SLAVES-1:0] sel_pend, sel_act;
  logic                own_q, own_d, oe_q, oe_d;

  jcs_rst_sync u_rst (.clk(tck), .arst_n(trst_n), .rst_n_o(rst_n));

  jcs_tap_fsm u_fsm (
    .tck(tck), .rst_n(rst_n), .tms(tms), .state_o(tap_state),
    .tlr_o(st_tlr), .idle_o(st_idle), .cap_dr_o(st_cap_dr), .sh_dr_o(st_sh_dr),
    .upd_dr_o(st_upd_dr), .cap_ir_o(st_cap_ir), .sh_ir_o(st_sh_ir), .upd_ir_o(st_upd_ir)
  );

  jcs_instr #(.IR_W(IR_W)) u_ir (
    .tck(tck), .rst_n(rst_n), .tlr(st_tlr), .cap_ir(st_cap_ir), .sh_ir(st_sh_ir),
    .upd_ir(st_upd_ir), .tdi(tdi), .ir_o(ir_q), .sr_lsb_o(ir_lsb)
  );

  assign sel_ir = (ir_q == SEL_CODE);

  jcs_sel_dr #(.N_SLV(N_SLAVES)) u_dr (
    .tck(tck), .rst_n(rst_n), .tlr(st_tlr), .idle(st_idle), .cap_dr(st_cap_dr),
    .sh_dr(st_sh_dr), .upd_dr(st_upd_dr), .sel_ir(sel_ir), .tdi(tdi),
    .dr_lsb_o(dr_lsb), .pend_o(sel_pend), .act_o(sel_act)
  );

  // switcher's own serial output, launched on the falling edge
  always_comb begin
    oe_d  = st_sh_ir | st_sh_dr;
    own_d = own_q;
    if (st_sh_ir)      own_d = ir_lsb;
    else if (st_sh_dr) own_d = dr_lsb;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      own_q <= own_d;
      oe_q  <= oe_d;
    end
  end

  jcs_route #(.N_SLV(N_SLAVES)) u_route (
    .tck(tck), .rst_n(rst_n), .act(sel_act), .own_bit(own_q), .slv_tdo(slv_tdo),
    .slv_tdi(slv_tdi), .slv_tck(slv_tck), .chain_o(tdo)
  );

  assign tdo_oe  = oe_q;
  assign slv_tms = {N_SLAVES{tms}};
  assign slv_en  = sel_act;
endmodule

// File: rtl/jcs_chk.sv
module jcs_chk #(
  parameter int N_SLV = 3,
  parameter int IR_W  = 4
) (
  input logic                tck,
  input logic                trst_n,
  input logic                tms,
  input logic                tdo_oe,
  input jcs_pkg::tap_state_e state,
  input logic [N_SLV-1:0]    pend,
  input logic [N_SLV-1:0]    act,
  input logic [IR_W-1:0]     ir
);
  import jcs_pkg::*;

  logic [2:0] ones_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)          ones_q <= 3'd0;
    else if (!tms)        ones_q <= 3'd0;
    else if (ones_q < 3'd5) ones_q <= ones_q + 3'd1;
  end

  a_r1_five_ones_reset: assert property (@(posedge tck) disable iff (!trst_n)
    (ones_q == 3'd5) |-> (state == TS_RESET));

  a_r3_oe_only_shift: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (state == TS_DR_SHIFT || state == TS_IR_SHIFT));

  a_r4_bypass_after_reset: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_RESET) |=> (ir == '1));

  a_r6_hold_outside_idle: assert property (@(posedge tck) disable iff (!trst_n)
    (state != TS_IDLE && state != TS_RESET) |=> $stable(act));

  a_r6_apply_in_idle: assert property (@(posedge tck) disable iff (!trst_n)
    (state == TS_IDLE) |=> (act == $past(pend)));
endmodule

bind jtag_chain_switch jcs_chk #(.N_SLV(N_SLAVES), .IR_W(IR_W)) u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .tdo_oe(tdo_oe), .state(tap_state),
  .pend(sel_pend), .act(sel_act), .ir(ir_q)
);

// File: tb/sim_jtag_chain_switch.sv
module jcs_slave_model (
  input  logic        clk,
  input  logic        din,
  output logic        dout,
  output logic [31:0] edges
);
  logic        b = 1'b0;
  logic        o = 1'b0;
  logic [31:0] e = 32'd0;
  always @(posedge clk) begin
    b <= din;
    e <= e + 32'd1;
  end
  always @(negedge clk) o <= b;
  assign dout  = o;
  assign edges = e;
endmodule

module sim_jtag_chain_switch;
  localparam int N = 3;
  localparam int IRW = 4;
  localparam logic [3:0] SEL = 4'b0010;
  localparam logic [3:0] BYP = 4'b1111;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic tdo, tdo_oe;
  logic [N-1:0] slv_tck, slv_tms, slv_tdi, slv_tdo, slv_en;
  logic [31:0] ecnt [N];
  int unsigned tck_cnt = 0;
  int n_chk = 0;
  int n_fail = 0;

  logic s_tdo, s_oe;
  logic [N-1:0] s_sdi, s_en;
  logic [63:0] r_tdo, r_oe;
  logic [N-1:0] r_sdi [64];

  always #5 tck = ~tck;
  always @(posedge tck) tck_cnt++;

  jtag_chain_switch #(.N_SLAVES(N), .IR_W(IRW), .SEL_CODE(SEL)) u0 (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .slv_tck(slv_tck), .slv_tms(slv_tms), .slv_tdi(slv_tdi), .slv_tdo(slv_tdo),
    .slv_en(slv_en)
  );

  for (genvar i = 0; i < N; i++) begin : g_m
    jcs_slave_model u_m (.clk(slv_tck[i]), .din(slv_tdi[i]), .dout(slv_tdo[i]), .edges(ecnt[i]));
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] a, input logic [63:0] e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, a, e);
    end
  endtask

  // one TCK cycle: sample outputs while tck is low, then set inputs for the next rising edge
  task automatic step(input logic m, input logic d);
    @(negedge tck);
    #1;
    s_tdo = tdo; s_oe = tdo_oe; s_sdi = slv_tdi; s_en = slv_en;
    chk(slv_tms === {N{tms}}, "R8 tms star", 64'(slv_tms), 64'({N{tms}}));
    tms = m;
    tdi = d;
  endtask

  task automatic scan(input bit is_ir, input int nb, input logic [63:0] d);
    step(1'b1, 1'b0);
    if (is_ir) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    for (int j = 0; j < nb; j++) begin
      step(j == nb - 1, d[j]);
      r_tdo[j] = s_tdo; r_oe[j] = s_oe; r_sdi[j] = s_sdi;
    end
    step(1'b1, 1'b0);
  endtask

  function automatic logic own_bit(input int k, input int lown, input logic [63:0] cap,
                                   input logic [63:0] d);
    return (k < lown) ? cap[k] : d[k - lown];
  endfunction

  task automatic check_scan(input string req, input int nb, input int lown,
                            input logic [63:0] cap, input logic [63:0] d, input logic [N-1:0] en);
    int c;
    c = $countones(en);
    for (int j = 0; j < nb; j++) begin
      int m;
      chk(r_oe[j] === 1'b1, "R3 oe in shift", 64'(r_oe[j]), 64'd1);
      if (j >= c)
        chk(r_tdo[j] === own_bit(j - c, lown, cap, d), req, 64'(r_tdo[j]),
            64'(own_bit(j - c, lown, cap, d)));
      m = 0;
      for (int i = 0; i < N; i++) begin
        if (en[i]) begin
          if (j >= m)
            chk(r_sdi[j][i] === own_bit(j - m, lown, cap, d), "R7 slave order",
                64'(r_sdi[j][i]), 64'(own_bit(j - m, lown, cap, d)));
          m++;
        end
      end
    end
  endtask

  task automatic load_ir(input logic [3:0] op, input logic [N-1:0] en);
    int c;
    logic [63:0] d;
    c = $countones(en);
    d = (64'(op) << c) | ((64'd1 << c) - 64'd1);
    scan(1'b1, IRW + c, d);
    step(1'b0, 1'b0);
    check_scan("R4 ir capture", IRW + c, IRW, 64'd1, d, en);
  endtask

  task automatic bypass_scan(input string req, input logic [N-1:0] en, input logic [63:0] d);
    logic [31:0] e0 [N];
    int unsigned t0;
    for (int i = 0; i < N; i++) e0[i] = ecnt[i];
    t0 = tck_cnt;
    scan(1'b0, 16, d);
    for (int i = 0; i < N; i++) begin
      if (en[i]) chk(ecnt[i] - e0[i] == tck_cnt - t0, "R8 enabled clock", 64'(ecnt[i] - e0[i]),
                     64'(tck_cnt - t0));
      else       chk(ecnt[i] == e0[i], "R8 gated clock", 64'(ecnt[i] - e0[i]), 64'd0);
    end
    step(1'b0, 1'b0);
    check_scan(req, 16, 1, 64'd0, d, en);
  endtask

  logic [N-1:0] cur;

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge tck);
    #1;
    chk(slv_en === '0 && tdo_oe === 1'b0, "R2 reset state", {slv_en, tdo_oe}, 64'd0);
    trst_n = 1'b1;
    repeat (6) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk(s_oe === 1'b0, "R3 oe low in idle", 64'(s_oe), 64'd0);

    // BYPASS is the code after reset; no slave in the chain
    bypass_scan("R4 bypass after reset", '0, 64'h0000_0000_0000_B5A3);

    cur = '0;
    for (int v = 0; v < (1 << N); v++) begin
      logic [N-1:0] vv;
      vv = N'(v);
      load_ir(SEL, cur);
      d = (64'(vv) << $countones(cur));
      scan(1'b0, N + $countones(cur), d);
      step(1'b0, 1'b0);
      check_scan("R5 select capture", N + $countones(cur), N, 64'(cur), d, cur);
      step(1'b0, 1'b0);
      chk(s_en === cur, "R6 hold on idle entry", 64'(s_en), 64'(cur));
      step(1'b0, 1'b0);
      chk(s_en === vv, "R6 applied in idle", 64'(s_en), 64'(vv));
      chk(s_oe === 1'b0, "R3 oe low in idle", 64'(s_oe), 64'd0);
      cur = vv;
      load_ir(BYP, cur);
      bypass_scan("R7 chain length", cur, 64'h0000_0000_0000_6C39 ^ 64'(v * 16'h1357));
    end

    // pending value must wait through a detour that avoids Run-Test/Idle
    load_ir(SEL, cur);
    d = 64'(3'b101) << $countones(cur);
    scan(1'b0, N + $countones(cur), d);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      step(1'b0, 1'b0);
      chk(s_en === cur, "R6 no apply outside idle", 64'(s_en), 64'(cur));
    end
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk(s_en === cur, "R6 hold on idle entry", 64'(s_en), 64'(cur));
    step(1'b0, 1'b0);
    chk(s_en === 3'b101, "R6 applied after detour", 64'(s_en), 64'h5);
    cur = 3'b101;
    // instruction now holds the captured value 1, a non-select code
    bypass_scan("R4 other code is bypass", cur, 64'h0000_0000_0000_9E27);

    // five TMS-high edges reset the controller
    load_ir(SEL, cur);
    repeat (5) step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    chk(s_en === '0, "R1 enables cleared", 64'(s_en), 64'd0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    cur = '0;
    bypass_scan("R1 ir back to bypass", cur, 64'h0000_0000_0000_47D1);

    // asynchronous reset in the middle of a scan
    load_ir(SEL, cur);
    scan(1'b0, N, 64'(3'b110));
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk(s_en === 3'b110, "R6 applied", 64'(s_en), 64'h6);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    chk(s_oe === 1'b1, "R3 oe in shift", 64'(s_oe), 64'd1);
    @(posedge tck);
    #2;
    trst_n = 1'b0;
    #1;
    chk(tdo_oe === 1'b0, "R2 async oe", 64'(tdo_oe), 64'd0);
    chk(slv_en === '0, "R2 async enables", 64'(slv_en), 64'd0);
    chk(slv_tck === '0, "R2 slave clocks low", 64'(slv_tck), 64'd0);
    #20;
    trst_n = 1'b1;
    repeat (6) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk(s_en === '0 && s_oe === 1'b0, "R2 after release", {s_en, s_oe}, 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule